// File: doc/BRIEF.md
# Grouped Multichannel FIFO Bridge with DMA Group Events

The block sits between a DMA engine and a multichannel sample converter. Every channel of the group owns two sample FIFOs: an ingress FIFO that the bus fills and the converter drains, and an egress FIFO that the converter fills and the bus drains. There is one bus write port and one bus read port for the whole group. Consecutive bus accesses go to the channels in turn, so a single data port interleaves one sample per channel and no per-channel address is needed.

Two level-type requests drive the DMA. The ingress request rises when every channel's ingress FIFO has room for at least the programmed ingress threshold. The egress request rises when every channel's egress FIFO holds at least the programmed egress threshold. The DMA answers a request with a burst of threshold × channel-count accesses, in as many steps as the threshold, each step touching every channel once in ascending order. A request stays up for as long as the DMA takes to start and complete its burst, drops after the last access of the burst, and is re-evaluated on the following cycle.

Bus writes into a full FIFO and bus reads from an empty FIFO are recorded in sticky error flags. Both thresholds come from one 32-bit control word.

Top module: `grouped_fifo_dma`

## Requirements
- R1: `inEvt` is raised only when the free space of every ingress FIFO is at least the effective ingress threshold; with even one channel short, it stays low.
- R2: `outEvt` is raised only when every egress FIFO holds at least the effective egress threshold samples.
- R3: The ingress threshold is read from `ctrlWord[7:0]` and the egress threshold from `ctrlWord[23:16]`; the other bits have no effect.
- R4: Bus writes go to channel 0, 1, ..., NCH-1 and then wrap back to channel 0, one channel per write, starting from channel 0 after reset.
- R5: Bus reads take from channel 0, 1, ..., NCH-1 and then wrap back to channel 0, one channel per read, starting from channel 0 after reset; `busRdData` shows the selected head in the same cycle as `busRdEn`.
- R6: A raised request stays high, however long the DMA waits, until its burst is served.
- R7: A request falls in the cycle after the threshold × NCH-th access of its direction and is re-evaluated in the next cycle, so it is low for at least one cycle between bursts.
- R8: A bus write to a full ingress FIFO is dropped and sets `errWrFull`, which stays set until reset.
- R9: A bus read from an empty egress FIFO returns zero and sets `errRdEmpty`, which stays set until reset.
- R10: A threshold field of zero acts as a threshold of one.
- R11: A threshold larger than the FIFO depth keeps the matching request low; a threshold equal to the depth is allowed.
- R12: Per channel, `convPopValid` is high while the ingress FIFO is non-empty and `convPopData` shows its oldest sample; `convPushReady` is low while the egress FIFO is full, and a push then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Group control word: ingress threshold [7:0], egress threshold [23:16] |
| busWrEn | input | 1 | Bus write strobe, one sample to the current write channel |
| busWrData | input | SW | Bus write sample |
| busRdEn | input | 1 | Bus read strobe, one sample from the current read channel |
| busRdData | output | SW | Bus read sample, zero when the channel is empty |
| inEvt | output | 1 | Ingress group DMA request |
| outEvt | output | 1 | Egress group DMA request |
| errWrFull | output | 1 | Sticky flag: bus write met a full FIFO |
| errRdEmpty | output | 1 | Sticky flag: bus read met an empty FIFO |
| convPop | input | NCH | Converter pop strobe per ingress FIFO |
| convPopData | output | NCH*SW | Head sample of each ingress FIFO, channel c at [c*SW +: SW] |
| convPopValid | output | NCH | Ingress FIFO non-empty, per channel |
| convPush | input | NCH | Converter push strobe per egress FIFO |
| convPushData | input | NCH*SW | Push sample per channel, channel c at [c*SW +: SW] |
| convPushReady | output | NCH | Egress FIFO not full, per channel |

## Verification
The properties take for granted that the DMA issues bus accesses of a direction only while that request is pending and stops after exactly threshold × NCH of them, and that the control word does not change in the middle of a burst; the request, pointer and sticky-flag properties then relate strobes to the FIFO levels seen one cycle before. The bench waits for each request before starting a burst, keeps the thresholds still during a burst, and changes them only while no burst is running. The only accesses outside a request window are single deliberate ones into a full or empty FIFO, used to provoke the error flags, and none of the properties depends on their absence.

// File: rtl/gfd_pkg.sv
package gfd_pkg;

  // Bit positions of the two threshold fields inside the control word.
  localparam int IN_THR_LSB  = 0;
  localparam int OUT_THR_LSB = 16;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrGo;
    logic rdGo;
  } gfd_strobe_t;

  // A zero threshold field behaves as one.
  function automatic logic [8:0] effThr(input logic [7:0] field);
    return (field == 8'd0) ? 9'd1 : {1'b0, field};
  endfunction

endpackage

// File: rtl/gfd_fifo.sv
module gfd_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  headData,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrIdx, rdIdx;
  logic          doPush, doPop;

  always_comb begin
    full     = (count == CW'(DEPTH));
    empty    = (count == '0);
    doPush   = push && !full;
    doPop    = pop && !empty;
    headData = mem[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrIdx] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (doPush) wrIdx <= (wrIdx == AW'(DEPTH - 1)) ? '0 : wrIdx + 1'b1;
      if (doPop)  rdIdx <= (rdIdx == AW'(DEPTH - 1)) ? '0 : rdIdx + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/gfd_datapath.sv
module gfd_datapath
  import gfd_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 16,
  parameter int SW    = 24,
  localparam int PW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gfd_strobe_t       strb,
  input  logic [PW-1:0]     wrSel,
  input  logic [PW-1:0]     rdSel,
  input  logic [SW-1:0]     busWrData,
  output logic [SW-1:0]     busRdData,
  input  logic [NCH-1:0]    convPop,
  output logic [NCH*SW-1:0] convPopData,
  output logic [NCH-1:0]    convPopValid,
  input  logic [NCH-1:0]    convPush,
  input  logic [NCH*SW-1:0] convPushData,
  output logic [NCH-1:0]    convPushReady,
  output logic              inFullSel,
  output logic              outEmptySel,
  output logic [LVW-1:0]    inMinFree,
  output logic [LVW-1:0]    outMinCnt
);

  logic [NCH-1:0] inFull, inEmpty, outFull, outEmpty;
  logic [SW-1:0]  inHead  [NCH];
  logic [SW-1:0]  outHead [NCH];
  logic [LVW-1:0] inCnt   [NCH];
  logic [LVW-1:0] inFree  [NCH];
  logic [LVW-1:0] outCnt  [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic inPush, outPop;
    assign inPush = strb.wrGo && (wrSel == PW'(ch));
    assign outPop = strb.rdGo && (rdSel == PW'(ch));

    gfd_fifo #(.W(SW), .DEPTH(DEPTH)) u_inFifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (inPush),
      .pushData (busWrData),
      .pop      (convPop[ch]),
      .headData (inHead[ch]),
      .full     (inFull[ch]),
      .empty    (inEmpty[ch]),
      .count    (inCnt[ch])
    );

    gfd_fifo #(.W(SW), .DEPTH(DEPTH)) u_outFifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (convPush[ch]),
      .pushData (convPushData[ch*SW +: SW]),
      .pop      (outPop),
      .headData (outHead[ch]),
      .full     (outFull[ch]),
      .empty    (outEmpty[ch]),
      .count    (outCnt[ch])
    );

    assign inFree[ch]                = LVW'(DEPTH) - inCnt[ch];
    assign convPopData[ch*SW +: SW]  = inHead[ch];
    assign convPopValid[ch]          = !inEmpty[ch];
    assign convPushReady[ch]         = !outFull[ch];
  end

  // Group-wide minimum levels feed the request logic.
  always_comb begin
    inMinFree = LVW'(DEPTH);
    outMinCnt = LVW'(DEPTH);
    for (int ch = 0; ch < NCH; ch++) begin
      if (inFree[ch] < inMinFree) inMinFree = inFree[ch];
      if (outCnt[ch] < outMinCnt) outMinCnt = outCnt[ch];
    end
  end

  always_comb begin
    inFullSel   = inFull[wrSel];
    outEmptySel = outEmpty[rdSel];
    busRdData   = outEmpty[rdSel] ? '0 : outHead[rdSel];
  end

endmodule

// File: rtl/gfd_evt_unit.sv
module gfd_evt_unit
  import gfd_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 16,
  localparam int PW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LVW  = $clog2(DEPTH + 1),
  localparam int LW   = 9 + PW
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [7:0]     thrField,
  input  logic [LVW-1:0] level,
  input  logic           access,
  output logic           evt,
  output logic [PW-1:0]  ptr
);

  logic [8:0]    thrEff;
  logic          ready;
  logic [LW-1:0] burstLen, burstCnt;

  always_comb begin
    thrEff = effThr(thrField);
    ready  = (int'(thrEff) <= DEPTH) && (int'(level) >= int'(thrEff));
  end

  // Request: raised on a ready group, held until the burst is done.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evt      <= 1'b0;
      burstLen <= '0;
      burstCnt <= '0;
    end else if (!evt) begin
      burstCnt <= '0;
      if (ready) begin
        evt      <= 1'b1;
        burstLen <= LW'(thrEff) * LW'(NCH);
      end
    end else if (access) begin
      if (burstCnt == burstLen - 1'b1) evt <= 1'b0;
      burstCnt <= burstCnt + 1'b1;
    end
  end

  // Channel pointer: steps on every access and wraps after the last channel.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (access) begin
      ptr <= (ptr == PW'(NCH - 1)) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/gfd_control.sv
module gfd_control
  import gfd_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 16,
  localparam int PW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [31:0]    ctrlWord,
  input  logic           busWrEn,
  input  logic           busRdEn,
  input  logic [LVW-1:0] inMinFree,
  input  logic [LVW-1:0] outMinCnt,
  input  logic           inFullSel,
  input  logic           outEmptySel,
  output gfd_strobe_t    strb,
  output logic [PW-1:0]  wrSel,
  output logic [PW-1:0]  rdSel,
  output logic           inEvt,
  output logic           outEvt,
  output logic           errWrFull,
  output logic           errRdEmpty
);

  logic [7:0] inThrField, outThrField;

  always_comb begin
    inThrField  = ctrlWord[IN_THR_LSB  +: 8];
    outThrField = ctrlWord[OUT_THR_LSB +: 8];
    strb.wrGo   = busWrEn;
    strb.rdGo   = busRdEn;
  end

  gfd_evt_unit #(.NCH(NCH), .DEPTH(DEPTH)) u_inEvt (
    .clk      (clk),
    .rstN     (rstN),
    .thrField (inThrField),
    .level    (inMinFree),
    .access   (busWrEn),
    .evt      (inEvt),
    .ptr      (wrSel)
  );

  gfd_evt_unit #(.NCH(NCH), .DEPTH(DEPTH)) u_outEvt (
    .clk      (clk),
    .rstN     (rstN),
    .thrField (outThrField),
    .level    (outMinCnt),
    .access   (busRdEn),
    .evt      (outEvt),
    .ptr      (rdSel)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errWrFull  <= 1'b0;
      errRdEmpty <= 1'b0;
    end else begin
      if (busWrEn && inFullSel)   errWrFull  <= 1'b1;
      if (busRdEn && outEmptySel) errRdEmpty <= 1'b1;
    end
  end

endmodule

// File: rtl/grouped_fifo_dma.sv
module grouped_fifo_dma
  import gfd_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 16,
  parameter int SW    = 24,
  localparam int PW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       ctrlWord,
  input  logic              busWrEn,
  input  logic [SW-1:0]     busWrData,
  input  logic              busRdEn,
  output logic [SW-1:0]     busRdData,
  output logic              inEvt,
  output logic              outEvt,
  output logic              errWrFull,
  output logic              errRdEmpty,
  input  logic [NCH-1:0]    convPop,
  output logic [NCH*SW-1:0] convPopData,
  output logic [NCH-1:0]    convPopValid,
  input  logic [NCH-1:0]    convPush,
  input  logic [NCH*SW-1:0] convPushData,
  output logic [NCH-1:0]    convPushReady
);

  gfd_strobe_t    strb;
  logic [PW-1:0]  wrSel, rdSel;
  logic           inFullSel, outEmptySel;
  logic [LVW-1:0] inMinFree, outMinCnt;

  gfd_control #(.NCH(NCH), .DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlWord    (ctrlWord),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .inMinFree   (inMinFree),
    .outMinCnt   (outMinCnt),
    .inFullSel   (inFullSel),
    .outEmptySel (outEmptySel),
    .strb        (strb),
    .wrSel       (wrSel),
    .rdSel       (rdSel),
    .inEvt       (inEvt),
    .outEvt      (outEvt),
    .errWrFull   (errWrFull),
    .errRdEmpty  (errRdEmpty)
  );

  gfd_datapath #(.NCH(NCH), .DEPTH(DEPTH), .SW(SW)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrSel         (wrSel),
    .rdSel         (rdSel),
    .busWrData     (busWrData),
    .busRdData     (busRdData),
    .convPop       (convPop),
    .convPopData   (convPopData),
    .convPopValid  (convPopValid),
    .convPush      (convPush),
    .convPushData  (convPushData),
    .convPushReady (convPushReady),
    .inFullSel     (inFullSel),
    .outEmptySel   (outEmptySel),
    .inMinFree     (inMinFree),
    .outMinCnt     (outMinCnt)
  );

endmodule

// File: rtl/gfd_checker.sv
module gfd_checker #(
  parameter int NCH   = 4,
  parameter int DEPTH = 16,
  localparam int PW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic [31:0]    ctrlWord,
  input logic           busWrEn,
  input logic           busRdEn,
  input logic           inEvt,
  input logic           outEvt,
  input logic           errWrFull,
  input logic           errRdEmpty,
  input logic [LVW-1:0] inMinFree,
  input logic [LVW-1:0] outMinCnt,
  input logic [PW-1:0]  wrSel,
  input logic [PW-1:0]  rdSel
);

  int inThr, outThr, wrNext, rdNext;

  always_comb begin
    inThr  = (ctrlWord[7:0]   == 8'd0) ? 1 : int'(ctrlWord[7:0]);
    outThr = (ctrlWord[23:16] == 8'd0) ? 1 : int'(ctrlWord[23:16]);
    wrNext = (int'(wrSel) == NCH - 1) ? 0 : int'(wrSel) + 1;
    rdNext = (int'(rdSel) == NCH - 1) ? 0 : int'(rdSel) + 1;
  end

  a_r1_in_evt_space: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inEvt) |-> $past(int'(inMinFree) >= inThr));

  a_r2_out_evt_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEvt) |-> $past(int'(outMinCnt) >= outThr));

  a_r11_in_big_thr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inEvt) |-> $past(inThr <= DEPTH));

  a_r11_out_big_thr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEvt) |-> $past(outThr <= DEPTH));

  a_r6_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    (inEvt && !busWrEn) |=> inEvt);

  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outEvt && !busRdEn) |=> outEvt);

  a_r4_wr_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> (int'(wrSel) == $past(wrNext)));

  a_r5_rd_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> (int'(rdSel) == $past(rdNext)));

  a_r4_wr_ptr_still: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(wrSel));

  a_r8_err_wr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errWrFull |=> errWrFull);

  a_r9_err_rd_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errRdEmpty |=> errRdEmpty);

  a_r9_err_rd_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errRdEmpty) |-> $past(busRdEn));

  a_r8_err_wr_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errWrFull) |-> $past(busWrEn));

endmodule

bind grouped_fifo_dma gfd_checker #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlWord   (ctrlWord),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .inEvt      (inEvt),
  .outEvt     (outEvt),
  .errWrFull  (errWrFull),
  .errRdEmpty (errRdEmpty),
  .inMinFree  (inMinFree),
  .outMinCnt  (outMinCnt),
  .wrSel      (wrSel),
  .rdSel      (rdSel)
);

// File: tb/sim_grouped_fifo_dma.sv
`timescale 1ns/1ps
module sim_grouped_fifo_dma;

  localparam int NCH   = 4;
  localparam int DEPTH = 16;
  localparam int SW    = 24;

  logic              clk = 1'b0;
  logic              rstN;
  logic [31:0]       ctrlWord;
  logic              busWrEn;
  logic [SW-1:0]     busWrData;
  logic              busRdEn;
  logic [SW-1:0]     busRdData;
  logic              inEvt, outEvt, errWrFull, errRdEmpty;
  logic [NCH-1:0]    convPop, convPopValid, convPush, convPushReady;
  logic [NCH*SW-1:0] convPopData, convPushData;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  grouped_fifo_dma #(.NCH(NCH), .DEPTH(DEPTH), .SW(SW)) u0 (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData),
    .inEvt(inEvt), .outEvt(outEvt),
    .errWrFull(errWrFull), .errRdEmpty(errRdEmpty),
    .convPop(convPop), .convPopData(convPopData), .convPopValid(convPopValid),
    .convPush(convPush), .convPushData(convPushData), .convPushReady(convPushReady)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic [31:0] cw);
    rstN = 1'b0; ctrlWord = cw;
    busWrEn = 1'b0; busWrData = '0; busRdEn = 1'b0;
    convPop = '0; convPush = '0; convPushData = '0;
    cyc(3);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [SW-1:0] d);
    busWrEn = 1'b1; busWrData = d;
    cyc(1);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(output logic [SW-1:0] d);
    busRdEn = 1'b1;
    #1 d = busRdData;
    cyc(1);
    busRdEn = 1'b0;
  endtask

  task automatic popCh(input int ch, output logic [SW-1:0] d);
    convPop = '0; convPop[ch] = 1'b1;
    #1 d = convPopData[ch*SW +: SW];
    cyc(1);
    convPop = '0;
  endtask

  task automatic pushCh(input int ch, input logic [SW-1:0] d);
    convPush = '0; convPush[ch] = 1'b1;
    convPushData[ch*SW +: SW] = d;
    cyc(1);
    convPush = '0;
  endtask

  task automatic wrBurst(input int b, input int n);
    while (!inEvt) cyc(1);
    for (int j = 0; j < n; j++) busWrite(SW'(b * 'h100 + j));
  endtask

  // Reset values and the first request on an empty group.
  task automatic testReset();
    doReset(32'h0000_0004);
    check(inEvt == 1'b0, "R1 reset inEvt", inEvt, 0);
    check(outEvt == 1'b0, "R2 reset outEvt", outEvt, 0);
    check({errWrFull, errRdEmpty} == 2'b00, "R8 R9 reset flags", {errWrFull, errRdEmpty}, 0);
    check(convPopValid == '0, "R12 reset popValid", convPopValid, 0);
    cyc(1);
    check(inEvt == 1'b1, "R1 empty group raises inEvt", inEvt, 1);
  endtask

  // Late service, one burst, ordering of the channels.
  task automatic testInBurst();
    logic [SW-1:0] d;
    doReset(32'h0000_0004);
    cyc(12);
    check(inEvt == 1'b1, "R6 request held while unserved", inEvt, 1);
    for (int j = 0; j < 4 * NCH; j++) begin
      if (j == 4 * NCH - 1) begin
        check(inEvt == 1'b1, "R7 request up before last access", inEvt, 1);
      end
      busWrite(SW'('h1000 + j));
    end
    check(inEvt == 1'b0, "R7 request drops after burst", inEvt, 0);
    cyc(1);
    check(inEvt == 1'b1, "R7 request re-evaluated", inEvt, 1);
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 4; k++) begin
        popCh(c, d);
        check(d == SW'('h1000 + k * NCH + c), "R4 write interleave", d, 'h1000 + k * NCH + c);
      end
    end
    check(convPopValid == '0, "R12 popValid after drain", convPopValid, 0);
  endtask

  // All-channel qualification, zero threshold, dropped write.
  task automatic testInFull();
    logic [SW-1:0] d;
    doReset(32'hFFFF_FF04);
    for (int b = 0; b < 4; b++) wrBurst(b, 4 * NCH);
    cyc(3);
    check(inEvt == 1'b0, "R1 full group no request", inEvt, 0);
    for (int c = 0; c < NCH - 1; c++) popCh(c, d);
    cyc(2);
    check(inEvt == 1'b0, "R1 one channel full blocks request", inEvt, 0);
    popCh(NCH - 1, d);
    cyc(2);
    check(inEvt == 1'b0, "R1 free space below threshold", inEvt, 0);
    ctrlWord = 32'hFFFF_FF00;
    cyc(2);
    check(inEvt == 1'b1, "R10 zero threshold acts as one", inEvt, 1);
    wrBurst(4, NCH);
    check(inEvt == 1'b0, "R7 burst of one step ends request", inEvt, 0);
    check(errWrFull == 1'b0, "R8 no error before overflow", errWrFull, 0);
    busWrite(SW'('hDEAD));
    check(errWrFull == 1'b1, "R8 overflow flagged", errWrFull, 1);
    for (int k = 0; k < DEPTH; k++) popCh(0, d);
    check(d == SW'('h400), "R8 last sample is not the dropped one", d, 'h400);
    check(convPopValid[0] == 1'b0, "R8 dropped write not stored", convPopValid[0], 0);
    cyc(3);
    check(errWrFull == 1'b1, "R8 flag sticky", errWrFull, 1);
  endtask

  // Egress qualification, read order, empty read.
  task automatic testOutBurst();
    logic [SW-1:0] d;
    doReset(32'hFF02_FF10);
    for (int k = 0; k < 2; k++)
      for (int c = 0; c < NCH; c++)
        if (!(k == 1 && c == NCH - 1)) pushCh(c, SW'('h2000 + k * 16 + c));
    cyc(2);
    check(outEvt == 1'b0, "R2 one channel short", outEvt, 0);
    check(inEvt == 1'b1, "R3 ingress field at [7:0] = 16", inEvt, 1);
    pushCh(NCH - 1, SW'('h2000 + 16 + NCH - 1));
    cyc(1);
    check(outEvt == 1'b1, "R2 R3 all channels hold threshold", outEvt, 1);
    for (int j = 0; j < 2 * NCH; j++) begin
      busRead(d);
      check(d == SW'('h2000 + (j / NCH) * 16 + (j % NCH)), "R5 read interleave", d,
            'h2000 + (j / NCH) * 16 + (j % NCH));
    end
    check(outEvt == 1'b0, "R7 egress request drops", outEvt, 0);
    cyc(2);
    check(outEvt == 1'b0, "R2 empty group stays low", outEvt, 0);
    busRead(d);
    check(d == '0, "R9 empty read returns zero", d, 0);
    check(errRdEmpty == 1'b1, "R9 underflow flagged", errRdEmpty, 1);
    cyc(3);
    check(errRdEmpty == 1'b1, "R9 flag sticky", errRdEmpty, 1);
  endtask

  // Oversized threshold, zero egress threshold, push backpressure.
  task automatic testThresholds();
    doReset(32'h0000_0011);
    cyc(4);
    check(inEvt == 1'b0, "R11 threshold above depth suppresses", inEvt, 0);
    ctrlWord = 32'h0000_0010;
    cyc(2);
    check(inEvt == 1'b1, "R11 threshold equal to depth allowed", inEvt, 1);
    for (int c = 0; c < NCH; c++) pushCh(c, SW'(c));
    cyc(1);
    check(outEvt == 1'b1, "R10 zero egress threshold acts as one", outEvt, 1);
    for (int k = 1; k < DEPTH; k++) pushCh(0, SW'(k));
    check(convPushReady[0] == 1'b0, "R12 full egress not ready", convPushReady[0], 0);
    check(convPushReady[1] == 1'b1, "R12 other channel ready", convPushReady[1], 1);
  endtask

  initial begin
    testReset();
    testInBurst();
    testInFull();
    testOutBurst();
    testThresholds();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule